// File: doc/BRIEF.md
# Shared-Dictionary Cache Line Compressor

This block shrinks one 64-byte cache line into a dictionary of up to eight distinct 32-bit words plus one 3-bit index for each of the line's sixteen 32-bit chunks. The line arrives as a 512-bit word over a valid/ready handshake. The block walks the chunks from chunk 0 to chunk 15, one per clock. A chunk whose value is already in the dictionary reuses that entry. A chunk with a new value claims the lowest free entry. If a ninth distinct value turns up, the line is declared incompressible.

The result is held on registered outputs: the dictionary words, their valid bits, the packed index field and a compressible flag. A one-cycle strobe marks a new result. A separate combinational expansion path rebuilds a 512-bit line from any dictionary and index field. A cache can therefore store the packed form and recover the data on a read.

Top module: `dict_line_packer`

## Requirements
- R1: After synchronous reset, `in_ready` is 1, `out_valid` is 0, and `out_dict_vals`, `out_dict_vld`, `out_ptrs` and `out_compressible` are all zero.
- R2: A line is taken on a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` stays 0 from the next cycle until the result is presented. `in_valid` and `in_line` have no effect on the result while `in_ready` is 0.
- R3: `out_valid` is a one-cycle pulse that rises 17 clock edges after the accepting edge, one edge per chunk plus one output register edge. `in_ready` is 1 in that same cycle. The result outputs keep their values until the next pulse.
- R4: Chunk k is `in_line[32k+31:32k]`. Dictionary entry e is `out_dict_vals[32e+31:32e]`, and its valid bit is `out_dict_vld[e]`. The index for chunk k is `out_ptrs[3k+2:3k]`.
- R5: Chunks are visited from 0 up to 15. A chunk equal to a valid entry gets that entry's index. A chunk with a new value is written into the lowest-numbered invalid entry, which becomes valid, and the chunk gets that index.
- R6: For a compressible line, entries that were never filled have valid bit 0 and value 0. The valid bits form a run of ones starting at bit 0.
- R7: When a chunk needs a new entry and all eight are valid, `out_compressible` is 0. In that case `out_dict_vld` is 8'hFF, `out_dict_vals` holds the first eight distinct values in chunk order, and `out_ptrs` is all zero. Otherwise `out_compressible` is 1.
- R8: The expansion path gives `dec_line[32k+31:32k]` equal to the `dec_dict` entry selected by `dec_ptrs[3k+2:3k]`. It does so combinationally, for any inputs.
- R9: Feeding a compressible result's `out_dict_vals` and `out_ptrs` into the expansion path returns exactly the accepted line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Line offered |
| in_ready | output | 1 | Block can take a line |
| in_line | input | 512 | Line to compress, chunk 0 in bits 31:0 |
| out_valid | output | 1 | One-cycle strobe for a new result |
| out_dict_vals | output | 256 | Eight 32-bit dictionary words |
| out_dict_vld | output | 8 | Valid bit per dictionary entry |
| out_ptrs | output | 48 | Sixteen 3-bit entry indices |
| out_compressible | output | 1 | Line fits in the dictionary |
| dec_dict | input | 256 | Dictionary for the expansion path |
| dec_ptrs | input | 48 | Index field for the expansion path |
| dec_line | output | 512 | Rebuilt line |

## Verification
Some internal faults corrupt the dictionary while the line is being walked: a missed match, a wrong free-slot priority, or an overflow flag that never sets. These show up at the outputs only once, in the result cycle, 17 edges after acceptance, as a wrong index, a doubled or skipped entry, or a wrong compressible flag. The reference model predicts every output on every cycle, so such a fault is reported at that strobe. A sequencing fault is seen at the first cycle where the handshake or strobe timing differs, and that can be as early as the cycle after acceptance. The round trip through the expansion path catches any encoding that is internally consistent but loses data.

// File: rtl/dlp_pkg.sv
package dlp_pkg;
    localparam int CHUNK_W  = 32;
    localparam int N_CHUNKS = 16;
    localparam int DICT_N   = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_EMIT = 2'd2
    } walk_state_t;
endpackage

// File: rtl/dlp_match.sv
module dlp_match #(
    parameter int CHUNK_W = dlp_pkg::CHUNK_W,
    parameter int DICT_N  = dlp_pkg::DICT_N,
    localparam int PW     = $clog2(DICT_N)
) (
    input  logic [CHUNK_W-1:0]        chunk,
    input  logic [DICT_N*CHUNK_W-1:0] dict_vals,
    input  logic [DICT_N-1:0]         dict_vld,
    output logic                      hit,
    output logic [PW-1:0]             hit_idx,
    output logic                      has_free,
    output logic [PW-1:0]             free_idx
);
    // Scan from the top so the lowest-numbered candidate wins.
    always_comb begin
        hit      = 1'b0;
        hit_idx  = '0;
        has_free = 1'b0;
        free_idx = '0;
        for (int e = DICT_N - 1; e >= 0; e--) begin
            if (dict_vld[e] && dict_vals[e*CHUNK_W +: CHUNK_W] == chunk) begin
                hit     = 1'b1;
                hit_idx = PW'(e);
            end
            if (!dict_vld[e]) begin
                has_free = 1'b1;
                free_idx = PW'(e);
            end
        end
    end
endmodule

// File: rtl/dlp_unpack.sv
module dlp_unpack #(
    parameter int CHUNK_W  = dlp_pkg::CHUNK_W,
    parameter int N_CHUNKS = dlp_pkg::N_CHUNKS,
    parameter int DICT_N   = dlp_pkg::DICT_N,
    localparam int PW      = $clog2(DICT_N)
) (
    input  logic [DICT_N*CHUNK_W-1:0]   dict_vals,
    input  logic [N_CHUNKS*PW-1:0]      ptrs,
    output logic [N_CHUNKS*CHUNK_W-1:0] line
);
    for (genvar k = 0; k < N_CHUNKS; k++) begin : g_lane
        logic [PW-1:0] sel;
        assign sel = ptrs[k*PW +: PW];
        assign line[k*CHUNK_W +: CHUNK_W] = dict_vals[sel*CHUNK_W +: CHUNK_W];
    end
endmodule

// File: rtl/dict_line_packer.sv
module dict_line_packer #(
    parameter int CHUNK_W  = dlp_pkg::CHUNK_W,
    parameter int N_CHUNKS = dlp_pkg::N_CHUNKS,
    parameter int DICT_N   = dlp_pkg::DICT_N,
    localparam int PW      = $clog2(DICT_N),
    localparam int CW      = $clog2(N_CHUNKS),
    localparam int LINE_W  = N_CHUNKS * CHUNK_W,
    localparam int DICT_W  = DICT_N * CHUNK_W,
    localparam int PTRS_W  = N_CHUNKS * PW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [LINE_W-1:0] in_line,
    output logic              out_valid,
    output logic [DICT_W-1:0] out_dict_vals,
    output logic [DICT_N-1:0] out_dict_vld,
    output logic [PTRS_W-1:0] out_ptrs,
    output logic              out_compressible,
    input  logic [DICT_W-1:0] dec_dict,
    input  logic [PTRS_W-1:0] dec_ptrs,
    output logic [LINE_W-1:0] dec_line
);
    import dlp_pkg::*;

    walk_state_t       st_q;
    logic [CW-1:0]     idx_q;
    logic [LINE_W-1:0] line_q;
    logic [DICT_W-1:0] dval_q;
    logic [DICT_N-1:0] dvld_q;
    logic [PTRS_W-1:0] ptr_q;
    logic              fail_q;

    logic [CHUNK_W-1:0] cur_chunk;
    logic               m_hit, m_free;
    logic [PW-1:0]      m_hit_idx, m_free_idx;

    assign cur_chunk = line_q[idx_q*CHUNK_W +: CHUNK_W];
    assign in_ready  = (st_q == ST_IDLE);

    dlp_match #(.CHUNK_W(CHUNK_W), .DICT_N(DICT_N)) u_match (
        .chunk     (cur_chunk),
        .dict_vals (dval_q),
        .dict_vld  (dvld_q),
        .hit       (m_hit),
        .hit_idx   (m_hit_idx),
        .has_free  (m_free),
        .free_idx  (m_free_idx)
    );

    dlp_unpack #(.CHUNK_W(CHUNK_W), .N_CHUNKS(N_CHUNKS), .DICT_N(DICT_N)) u_unpack (
        .dict_vals (dec_dict),
        .ptrs      (dec_ptrs),
        .line      (dec_line)
    );

    // Chunk walk: one chunk per edge while running.
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            idx_q  <= '0;
            line_q <= '0;
            dval_q <= '0;
            dvld_q <= '0;
            ptr_q  <= '0;
            fail_q <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (in_valid) begin
                        st_q   <= ST_RUN;
                        idx_q  <= '0;
                        line_q <= in_line;
                        dval_q <= '0;
                        dvld_q <= '0;
                        ptr_q  <= '0;
                        fail_q <= 1'b0;
                    end
                end
                ST_RUN: begin
                    if (!fail_q) begin
                        if (m_hit) begin
                            ptr_q[idx_q*PW +: PW] <= m_hit_idx;
                        end else if (m_free) begin
                            dval_q[m_free_idx*CHUNK_W +: CHUNK_W] <= cur_chunk;
                            dvld_q[m_free_idx]                    <= 1'b1;
                            ptr_q[idx_q*PW +: PW]                 <= m_free_idx;
                        end else begin
                            fail_q <= 1'b1;
                        end
                    end
                    idx_q <= idx_q + 1'b1;
                    if (idx_q == CW'(N_CHUNKS - 1)) st_q <= ST_EMIT;
                end
                ST_EMIT: st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Output register stage.
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid        <= 1'b0;
            out_dict_vals    <= '0;
            out_dict_vld     <= '0;
            out_ptrs         <= '0;
            out_compressible <= 1'b0;
        end else begin
            out_valid <= (st_q == ST_EMIT);
            if (st_q == ST_EMIT) begin
                out_dict_vals    <= dval_q;
                out_dict_vld     <= dvld_q;
                out_ptrs         <= fail_q ? '0 : ptr_q;
                out_compressible <= !fail_q;
            end
        end
    end
endmodule

// File: rtl/dlp_checker.sv
module dlp_checker #(
    parameter int CHUNK_W  = dlp_pkg::CHUNK_W,
    parameter int N_CHUNKS = dlp_pkg::N_CHUNKS,
    parameter int DICT_N   = dlp_pkg::DICT_N,
    localparam int PW      = $clog2(DICT_N)
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        in_valid,
    input logic                        in_ready,
    input logic                        out_valid,
    input logic [DICT_N*CHUNK_W-1:0]   out_dict_vals,
    input logic [DICT_N-1:0]           out_dict_vld,
    input logic [N_CHUNKS*PW-1:0]      out_ptrs,
    input logic                        out_compressible
);
    logic ptrs_land_valid;
    logic unused_zero;

    always_comb begin
        ptrs_land_valid = 1'b1;
        for (int k = 0; k < N_CHUNKS; k++) begin
            if (!out_dict_vld[out_ptrs[k*PW +: PW]]) ptrs_land_valid = 1'b0;
        end
        unused_zero = 1'b1;
        for (int e = 0; e < DICT_N; e++) begin
            if (!out_dict_vld[e] && out_dict_vals[e*CHUNK_W +: CHUNK_W] != '0) unused_zero = 1'b0;
        end
    end

    assert_busy_after_take_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);

    assert_strobe_single_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    assert_ready_at_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> in_ready);

    assert_held_between_R3: assert property (@(posedge clk) disable iff (rst)
        !out_valid |=> (out_valid || ($stable(out_ptrs) && $stable(out_dict_vld) && $stable(out_compressible))));

    assert_ptrs_valid_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_compressible) |-> ptrs_land_valid);

    assert_vld_run_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (((out_dict_vld + 1'b1) & out_dict_vld) == '0));

    assert_unused_zero_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> unused_zero);

    assert_overflow_shape_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_compressible) |-> (&out_dict_vld && out_ptrs == '0));
endmodule

bind dict_line_packer dlp_checker #(
    .CHUNK_W(CHUNK_W), .N_CHUNKS(N_CHUNKS), .DICT_N(DICT_N)
) u_dlp_checker (
    .clk              (clk),
    .rst              (rst),
    .in_valid         (in_valid),
    .in_ready         (in_ready),
    .out_valid        (out_valid),
    .out_dict_vals    (out_dict_vals),
    .out_dict_vld     (out_dict_vld),
    .out_ptrs         (out_ptrs),
    .out_compressible (out_compressible)
);

// File: tb/dict_line_packer_bench.sv
`timescale 1ns/1ps
module dict_line_packer_bench;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic         in_ready;
    logic [511:0] in_line;
    logic         out_valid;
    logic [255:0] out_dict_vals;
    logic [7:0]   out_dict_vld;
    logic [47:0]  out_ptrs;
    logic         out_compressible;
    logic [255:0] dec_dict;
    logic [47:0]  dec_ptrs;
    logic [511:0] dec_line;

    int n_tests = 0;
    int n_fail  = 0;
    bit chk_en  = 1'b0;

    always #2 clk = ~clk;

    dict_line_packer u_dict_line_packer (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_line(in_line), .out_valid(out_valid), .out_dict_vals(out_dict_vals),
        .out_dict_vld(out_dict_vld), .out_ptrs(out_ptrs),
        .out_compressible(out_compressible), .dec_dict(dec_dict),
        .dec_ptrs(dec_ptrs), .dec_line(dec_line)
    );

    // Reference model state.
    int           m_cnt = 0;
    bit           m_ov  = 1'b0;
    logic [511:0] m_line = '0;
    logic [255:0] e_vals = '0;
    logic [7:0]   e_vld  = '0;
    logic [47:0]  e_ptrs = '0;
    bit           e_ok   = 1'b0;
    logic [255:0] n_vals;
    logic [7:0]   n_vld;
    logic [47:0]  n_ptrs;
    bit           n_ok;

    task automatic model_line(input logic [511:0] ln);
        logic [31:0] v [8];
        int used;
        used   = 0;
        n_ok   = 1'b1;
        n_vals = '0;
        n_ptrs = '0;
        for (int k = 0; k < 16; k++) begin
            logic [31:0] c;
            int f;
            c = ln[k*32 +: 32];
            f = -1;
            for (int e = used - 1; e >= 0; e--) if (v[e] == c) f = e;
            if (f < 0) begin
                if (used < 8) begin
                    v[used] = c;
                    n_vals[used*32 +: 32] = c;
                    f = used;
                    used++;
                end else n_ok = 1'b0;
            end
            if (f >= 0) n_ptrs[k*3 +: 3] = 3'(f);
        end
        n_vld = '0;
        for (int e = 0; e < used; e++) n_vld[e] = 1'b1;
        if (!n_ok) n_ptrs = '0;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_ov = 1'b0;
            e_vals = '0; e_vld = '0; e_ptrs = '0; e_ok = 1'b0;
        end else begin
            m_ov = (m_cnt == 17);
            if (m_cnt == 17) begin
                m_cnt = 0;
                model_line(m_line);
                e_vals = n_vals; e_vld = n_vld; e_ptrs = n_ptrs; e_ok = n_ok;
            end else if (m_cnt > 0) m_cnt++;
            else if (in_valid) begin
                m_cnt  = 1;
                m_line = in_line;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [511:0] act, input logic [511:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (chk_en) begin
            check(in_ready == (m_cnt == 0), "R2", "in_ready", 512'(in_ready), 512'(m_cnt == 0));
            check(out_valid == m_ov, "R3", "out_valid", 512'(out_valid), 512'(m_ov));
            check(out_dict_vals == e_vals, "R5", "dict values", 512'(out_dict_vals), 512'(e_vals));
            check(out_dict_vld == e_vld, "R6", "dict valid", 512'(out_dict_vld), 512'(e_vld));
            check(out_ptrs == e_ptrs, "R4", "pointers", 512'(out_ptrs), 512'(e_ptrs));
            check(out_compressible == e_ok, "R7", "compressible", 512'(out_compressible), 512'(e_ok));
            if (m_ov && e_ok) begin
                dec_dict = out_dict_vals;
                dec_ptrs = out_ptrs;
                #0.5;
                check(dec_line == m_line, "R9", "round trip", dec_line, m_line);
            end
        end
    end

    task automatic send(input logic [511:0] ln, input bit noisy);
        while (m_cnt != 0) @(negedge clk);
        in_valid = 1'b1;
        in_line  = ln;
        @(negedge clk);
        if (noisy) in_line = ~ln ^ {16{32'h1357_9bdf}};
        else in_valid = 1'b0;
        while (m_cnt != 0) @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic unpack_probe();
        logic [511:0] exp;
        @(negedge clk);
        for (int e = 0; e < 8; e++) dec_dict[e*32 +: 32] = $urandom;
        for (int k = 0; k < 16; k++) dec_ptrs[k*3 +: 3] = 3'($urandom);
        for (int k = 0; k < 16; k++) exp[k*32 +: 32] = dec_dict[dec_ptrs[k*3 +: 3]*32 +: 32];
        #0.5;
        check(dec_line == exp, "R8", "expansion", dec_line, exp);
    endtask

    initial begin
        #(4 * 20000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [511:0] ln;
        logic [31:0]  alpha [4];
        rst = 1'b1; in_valid = 1'b0; in_line = '0; dec_dict = '0; dec_ptrs = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(in_ready == 1'b1 && out_valid == 1'b0, "R1", "handshake after reset",
              512'({in_ready, out_valid}), 512'(2'b10));
        check(out_dict_vld == '0 && out_ptrs == '0 && out_dict_vals == '0 && !out_compressible,
              "R1", "result after reset", 512'(out_ptrs), 512'(0));
        chk_en = 1'b1;

        // R5: all-zero line uses one entry
        send('0, 1'b0);
        // R7: sixteen distinct values overflow at chunk 8
        for (int k = 0; k < 16; k++) ln[k*32 +: 32] = (k + 1) * 32'h0101_0101;
        send(ln, 1'b0);
        // R5/R6: exactly eight distinct values, busy input noisy (R2)
        for (int k = 0; k < 16; k++) ln[k*32 +: 32] = 32'hA000_0000 + (k % 8) * 7;
        send(ln, 1'b1);
        // R7: ninth distinct value only in chunk 15
        for (int k = 0; k < 15; k++) ln[k*32 +: 32] = 32'h5500_0000 + (k % 8);
        ln[15*32 +: 32] = 32'hDEAD_BEEF;
        send(ln, 1'b0);
        // R5: two alternating values
        for (int k = 0; k < 16; k++) ln[k*32 +: 32] = (k % 2) ? 32'hFFFF_FFFF : 32'h1234_5678;
        send(ln, 1'b0);
        // R5: chunk 0 unique, rest repeated
        for (int k = 0; k < 16; k++) ln[k*32 +: 32] = (k == 0) ? 32'h0 : 32'hCAFE_F00D;
        send(ln, 1'b1);
        // small alphabet and fully random lines
        for (int t = 0; t < 6; t++) begin
            for (int a = 0; a < 4; a++) alpha[a] = $urandom;
            for (int k = 0; k < 16; k++) ln[k*32 +: 32] = alpha[$urandom % 4];
            send(ln, t[0]);
        end
        for (int t = 0; t < 3; t++) begin
            for (int k = 0; k < 16; k++) ln[k*32 +: 32] = $urandom;
            send(ln, 1'b0);
        end
        // R3: results held while idle
        repeat (5) @(negedge clk);
        chk_en = 1'b0;
        for (int t = 0; t < 8; t++) unpack_probe();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule